// File: doc/BRIEF.md
# Clock Generator Power Sequencer with Strap Capture

This block manages the power states of a clock generator. While the power-on reset is held, four dual-purpose pins are read as configuration straps. The block captures their levels into a register and, once reset ends, turns the pins into outputs so they can carry clocks. The captured value is kept for the whole power-on period. Leaving a power-down does not re-read the pins.

The block also handles an asynchronous, active-low power-down request. After the request is synchronized, every output-enable group drops at once, so the clocks park low. The block then waits a parameterized number of cycles so that the slow reference and fixed-frequency domains can reach their low state. Next it disables the VCO, and on the following cycle it disables the crystal oscillator. When the request is released, the order reverses. The crystal comes on first and a stabilization count runs. Then the VCO comes on and a lock count runs. Only after both counts are the outputs released. The oscillator and PLL appear here only as enable signals.

In the running state, the CPU and PCI group enables follow their own synchronized stop inputs. In every other state those stop inputs have no effect.

Top module: `clkpd_power_ctrl`

## Requirements
- R1: `strap_o` equals the level of `strap_pins_i` at the last rising clock edge on which `rst` was high. Pin activity after reset does not change it.
- R2: `pin_oe_o` is 0 while `rst` is high. It becomes 1 at the first rising edge with `rst` low and stays 1.
- R3: `pd_n_i` passes through a two-flop synchronizer. A change driven between edges first shows up in `status_o` at the third rising edge that follows. The `status_o` codes are: 0 = running, 1 = stopping, 2 = down, 3 = waking.
- R4: At the edge where `status_o` goes from running to stopping, `cpu_en_o`, `pci_en_o` and `free_en_o` all become 0. They stay 0 until the wake sequence finishes.
- R5: `vco_en_o` falls PARK_CYC edges after the outputs stop. `xtal_en_o` falls one edge after that, at the same edge where `status_o` becomes down.
- R6: While `status_o` is not running, `cpu_stop_n_i` and `pci_stop_n_i` have no effect on any output.
- R7: When `pd_n_i` is released from the down state, `xtal_en_o` rises at the third edge after the release. `vco_en_o` rises XTAL_CYC edges later. After a further LOCK_CYC edges, `status_o` returns to running and the output enables are released.
- R8: In the running state, `cpu_en_o` and `pci_en_o` each follow their own stop input with a latency of three edges. `free_en_o` stays 1 regardless of either stop input.
- R9: A full power-down and wake cycle leaves `strap_o` unchanged.
- R10: A power-down sequence that has started always runs through to the down state, even if the request is released early. The VCO is never enabled while the crystal is disabled.
- R11: While `rst` is high, the state is: all output enables 0, `xtal_en_o` = 1, `vco_en_o` = 1, `status_o` = 0 and `pin_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU-domain clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_pins_i | input | STRAP_W | Levels on the dual-purpose pins |
| pd_n_i | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n_i | input | 1 | Asynchronous CPU group stop, active low |
| pci_stop_n_i | input | 1 | Asynchronous PCI group stop, active low |
| strap_o | output | STRAP_W | Captured strap value |
| pin_oe_o | output | 1 | 1 = the dual-purpose pins drive clocks |
| cpu_en_o | output | 1 | CPU/SDRAM group enable (0 = held low) |
| pci_en_o | output | 1 | Stoppable PCI group enable |
| free_en_o | output | 1 | Enable for the free-running, REF and 48 MHz group |
| vco_en_o | output | 1 | VCO enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| status_o | output | 2 | Power state code |

## Verification
Every asynchronous input passes through two synchronizer flops and then one output register. A change driven between edges therefore first appears after the third rising edge. The bench drives on falling edges and samples on the falling edge after each rising edge. For each cycle of a power-down it works out the state, the crystal and VCO enables and the group enables from PARK_CYC, XTAL_CYC and LOCK_CYC, and it does the same for each cycle of the wake-up. Where latency matters, the bench also checks the cycle before each transition. The strap capture is swept over all sixteen values.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

  typedef enum logic [2:0] {
    S_RUN   = 3'd0,
    S_PARK  = 3'd1,
    S_VOFF  = 3'd2,
    S_DOWN  = 3'd3,
    S_WXTAL = 3'd4,
    S_WVCO  = 3'd5
  } seq_st_t;

  localparam logic [1:0] STAT_RUN      = 2'd0;
  localparam logic [1:0] STAT_STOPPING = 2'd1;
  localparam logic [1:0] STAT_DOWN     = 2'd2;
  localparam logic [1:0] STAT_WAKING   = 2'd3;

  function automatic logic [1:0] status_of(input seq_st_t s);
    case (s)
      S_RUN:          status_of = STAT_RUN;
      S_PARK, S_VOFF: status_of = STAT_STOPPING;
      S_DOWN:         status_of = STAT_DOWN;
      default:        status_of = STAT_WAKING;
    endcase
  endfunction

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/clkpd_strap_latch.sv
module clkpd_strap_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] strap_o,
  output logic         pin_oe_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_o  <= pins_i;
      pin_oe_o <= 1'b0;
    end else begin
      pin_oe_o <= 1'b1;
    end
  end

  // R1 / R9: once out of reset the captured straps never move
  p_strap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_o));

  // R2: pins stay outputs once released
  p_oe_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    $past(pin_oe_o) |-> pin_oe_o);

endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
  import clkpd_pkg::*;
#(
  parameter int PARK_CYC = 4,
  parameter int XTAL_CYC = 64,
  parameter int LOCK_CYC = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_n_s,
  input  logic       cpu_go_s,
  input  logic       pci_go_s,
  output logic       cpu_en_o,
  output logic       pci_en_o,
  output logic       free_en_o,
  output logic       vco_en_o,
  output logic       xtal_en_o,
  output logic [1:0] status_o
);

  localparam int MAX_AB = (PARK_CYC > XTAL_CYC) ? PARK_CYC : XTAL_CYC;
  localparam int MAXC   = (MAX_AB > LOCK_CYC) ? MAX_AB : LOCK_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PARK_LAST = CW'(PARK_CYC - 1);
  localparam logic [CW-1:0] XTAL_LAST = CW'(XTAL_CYC - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

  seq_st_t       st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt + 1'b1;
    case (st)
      S_RUN: begin
        cnt_nx = '0;
        if (!pd_n_s) st_nx = S_PARK;
      end
      S_PARK: begin
        if (cnt == PARK_LAST) begin
          st_nx  = S_VOFF;
          cnt_nx = '0;
        end
      end
      S_VOFF: begin
        st_nx  = S_DOWN;
        cnt_nx = '0;
      end
      S_DOWN: begin
        cnt_nx = '0;
        if (pd_n_s) st_nx = S_WXTAL;
      end
      S_WXTAL: begin
        if (cnt == XTAL_LAST) begin
          st_nx  = S_WVCO;
          cnt_nx = '0;
        end
      end
      S_WVCO: begin
        if (cnt == LOCK_LAST) begin
          st_nx  = S_RUN;
          cnt_nx = '0;
        end
      end
      default: begin
        st_nx  = S_RUN;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_RUN;
      cnt       <= '0;
      cpu_en_o  <= 1'b0;
      pci_en_o  <= 1'b0;
      free_en_o <= 1'b0;
      vco_en_o  <= 1'b1;
      xtal_en_o <= 1'b1;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      cpu_en_o  <= (st_nx == S_RUN) && cpu_go_s;
      pci_en_o  <= (st_nx == S_RUN) && pci_go_s;
      free_en_o <= (st_nx == S_RUN);
      vco_en_o  <= !(st_nx inside {S_VOFF, S_DOWN, S_WXTAL});
      xtal_en_o <= (st_nx != S_DOWN);
    end
  end

  assign status_o = status_of(st);

  // R10: VCO can only run on a live crystal
  p_vco_needs_xtal_r10: assert property (@(posedge clk) disable iff (rst)
    !xtal_en_o |-> !vco_en_o);

  // R4: all output groups are parked before the VCO is off
  p_parked_before_vco_r4: assert property (@(posedge clk) disable iff (rst)
    !vco_en_o |-> !(cpu_en_o || pci_en_o || free_en_o));

  // R5: crystal goes off only after the VCO already was
  p_xtal_after_vco_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(xtal_en_o) |-> $past(!vco_en_o));

  // R7: no output released while waking
  p_quiet_waking_r7: assert property (@(posedge clk) disable iff (rst)
    (status_o == STAT_WAKING) |-> !(cpu_en_o || pci_en_o || free_en_o));

  // R3: counter stays inside its window
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAXC));

endmodule

// File: rtl/clkpd_power_ctrl.sv
module clkpd_power_ctrl #(
  parameter int STRAP_W  = 4,
  parameter int SYNC_STG = 2,
  parameter int PARK_CYC = 4,
  parameter int XTAL_CYC = 64,
  parameter int LOCK_CYC = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_pins_i,
  input  logic               pd_n_i,
  input  logic               cpu_stop_n_i,
  input  logic               pci_stop_n_i,
  output logic [STRAP_W-1:0] strap_o,
  output logic               pin_oe_o,
  output logic               cpu_en_o,
  output logic               pci_en_o,
  output logic               free_en_o,
  output logic               vco_en_o,
  output logic               xtal_en_o,
  output logic [1:0]         status_o
);

  localparam int NREQ = 3;

  logic [NREQ-1:0] req_raw, req_s;

  assign req_raw = {pd_n_i, cpu_stop_n_i, pci_stop_n_i};

  clkpd_strap_latch #(.W(STRAP_W)) u_strap (
    .clk      (clk),
    .rst      (rst),
    .pins_i   (strap_pins_i),
    .strap_o  (strap_o),
    .pin_oe_o (pin_oe_o)
  );

  clkpd_sync #(.W(NREQ), .STAGES(SYNC_STG), .RST_VAL({NREQ{1'b1}})) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (req_raw),
    .q_o (req_s)
  );

  clkpd_seq #(
    .PARK_CYC (PARK_CYC),
    .XTAL_CYC (XTAL_CYC),
    .LOCK_CYC (LOCK_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pd_n_s    (req_s[2]),
    .cpu_go_s  (req_s[1]),
    .pci_go_s  (req_s[0]),
    .cpu_en_o  (cpu_en_o),
    .pci_en_o  (pci_en_o),
    .free_en_o (free_en_o),
    .vco_en_o  (vco_en_o),
    .xtal_en_o (xtal_en_o),
    .status_o  (status_o)
  );

endmodule

// File: tb/test_clkpd_power_ctrl.sv
`timescale 1ns/1ps
module test_clkpd_power_ctrl;

  localparam int P = 3;
  localparam int X = 5;
  localparam int L = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] pins;
  logic       pd_n, cpu_stop_n, pci_stop_n;
  logic [3:0] strap_o;
  logic       pin_oe_o, cpu_en_o, pci_en_o, free_en_o, vco_en_o, xtal_en_o;
  logic [1:0] status_o;

  int n_cmp = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  clkpd_power_ctrl #(
    .STRAP_W(4), .SYNC_STG(2), .PARK_CYC(P), .XTAL_CYC(X), .LOCK_CYC(L)
  ) i_clkpd_power_ctrl (
    .clk(clk), .rst(rst), .strap_pins_i(pins), .pd_n_i(pd_n),
    .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n),
    .strap_o(strap_o), .pin_oe_o(pin_oe_o), .cpu_en_o(cpu_en_o),
    .pci_en_o(pci_en_o), .free_en_o(free_en_o), .vco_en_o(vco_en_o),
    .xtal_en_o(xtal_en_o), .status_o(status_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; pins = '0; pd_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    @(negedge clk);

    // R1, R2, R11: exhaustive strap sweep
    for (int v = 0; v < 16; v++) begin
      rst  = 1'b1;
      pins = 4'(v);
      tick(2);
      if (v == 0) begin
        chk("R11", "cpu_en", int'(cpu_en_o), 0);
        chk("R11", "pci_en", int'(pci_en_o), 0);
        chk("R11", "free_en", int'(free_en_o), 0);
        chk("R11", "xtal_en", int'(xtal_en_o), 1);
        chk("R11", "vco_en", int'(vco_en_o), 1);
        chk("R11", "status", int'(status_o), 0);
      end
      chk("R2", "pin_oe in reset", int'(pin_oe_o), 0);
      rst  = 1'b0;
      pins = ~4'(v);
      tick(1);
      chk("R2", "pin_oe after reset", int'(pin_oe_o), 1);
      chk("R1", "strap", int'(strap_o), v);
      pins = 4'(v ^ 5);
      tick(3);
      chk("R1", "strap held", int'(strap_o), v);
      chk("R8", "free_en running", int'(free_en_o), 1);
    end

    // R8: stop inputs in running state, 3-edge latency
    cpu_stop_n = 1'b0;
    tick(2);
    chk("R8", "cpu_en before latency", int'(cpu_en_o), 1);
    tick(1);
    chk("R8", "cpu_en stopped", int'(cpu_en_o), 0);
    chk("R8", "pci_en untouched", int'(pci_en_o), 1);
    chk("R8", "free_en untouched", int'(free_en_o), 1);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b0;
    tick(3);
    chk("R8", "cpu_en restarted", int'(cpu_en_o), 1);
    chk("R8", "pci_en stopped", int'(pci_en_o), 0);
    chk("R8", "free_en with pci stop", int'(free_en_o), 1);
    pci_stop_n = 1'b1;
    tick(3);
    chk("R8", "pci_en restarted", int'(pci_en_o), 1);

    // R3, R4, R5, R6: power-down, cycle by cycle
    pd_n = 1'b0;
    for (int k = 1; k <= P + 7; k++) begin
      int e_st, e_run;
      tick(1);
      e_st  = (k < 3) ? 0 : (k < 4 + P) ? 1 : 2;
      e_run = (k < 3) ? 1 : 0;
      chk("R3", "status pd", int'(status_o), e_st);
      chk("R4", "cpu_en pd", int'(cpu_en_o), e_run);
      chk("R6", "pci_en pd", int'(pci_en_o), e_run);
      chk("R4", "free_en pd", int'(free_en_o), e_run);
      chk("R5", "vco_en pd", int'(vco_en_o), (k < 3 + P) ? 1 : 0);
      chk("R5", "xtal_en pd", int'(xtal_en_o), (k < 4 + P) ? 1 : 0);
      cpu_stop_n = k[0];
      pci_stop_n = ~k[0];
      pins = 4'(k);
    end

    // R7: wake-up, cycle by cycle
    cpu_stop_n = 1'b0; pci_stop_n = 1'b1;
    pd_n = 1'b1;
    for (int k = 1; k <= X + L + 5; k++) begin
      int e_st, e_free;
      tick(1);
      e_st   = (k < 3) ? 2 : (k < 3 + X + L) ? 3 : 0;
      e_free = (k >= 3 + X + L) ? 1 : 0;
      chk("R7", "status wake", int'(status_o), e_st);
      chk("R7", "xtal_en wake", int'(xtal_en_o), (k >= 3) ? 1 : 0);
      chk("R7", "vco_en wake", int'(vco_en_o), (k >= 3 + X) ? 1 : 0);
      chk("R7", "free_en wake", int'(free_en_o), e_free);
      chk("R6", "cpu_en wake", int'(cpu_en_o), 0);
      chk("R7", "pci_en wake", int'(pci_en_o), e_free);
    end
    chk("R9", "strap after pd cycle", int'(strap_o), 15);
    chk("R9", "pin_oe after pd cycle", int'(pin_oe_o), 1);

    // R10: early release still completes the sequence
    pd_n = 1'b0;
    tick(4);
    pd_n = 1'b1;
    tick(P);
    chk("R10", "status reaches down", int'(status_o), 2);
    chk("R10", "xtal_en off", int'(xtal_en_o), 0);
    chk("R10", "vco_en off", int'(vco_en_o), 0);
    tick(1);
    chk("R10", "status waking", int'(status_o), 3);
    chk("R10", "xtal_en back", int'(xtal_en_o), 1);
    chk("R10", "vco_en still off", int'(vco_en_o), 0);
    tick(X + L - 1);
    chk("R10", "status still waking", int'(status_o), 3);
    tick(1);
    chk("R10", "status running", int'(status_o), 0);
    chk("R10", "free_en running", int'(free_en_o), 1);
    chk("R9", "strap final", int'(strap_o), 15);

    summary();
    $finish;
  end

endmodule